// File: doc/BRIEF.md
# Fractional-Rate Time-of-Day Counter

This block keeps a precision time of day as three parts: a seconds count, a nanoseconds-within-second count and a 32-bit fraction of a nanosecond. While it is enabled, each core clock cycle adds a programmable 32.32 fixed-point step to the nanosecond and fraction pair. Software trims the rate of time by changing that step, and does the frequency arithmetic itself.

Software also corrects the time without stopping it. A one-shot operation code can load a complete new time from staging registers, or add or subtract a staged nanosecond amount. Each correction lands on one clock edge, with any carry into or borrow from the seconds count. Two second-boundary points, the current one and the next one, set the length of the running second. At each rollover they move forward by a programmable second length.

Top module: `tod_counter`

## Requirements
- R1: While the enable bit is set, each clock adds the step register (bits 63:32 whole nanoseconds, bits 31:0 fraction) to the {nanoseconds, fraction} pair.
- R2: While the enable bit is clear, the step is not added and the time holds. Operations still apply.
- R3: When the pair reaches the span (next boundary minus current boundary) nanoseconds, the span is subtracted and the excess is kept. Seconds increment, current takes next, and next grows by the second-length register.
- R4: The control register (address 0) holds enable in bit 0 and the operation code in bits 28:26: 1 = load, 3 = add, 4 = subtract. A code applies at the clock edge after the write that sets it, and reads back as 0 after that edge.
- R5: Load copies staged nanoseconds (address 2), fraction (3), seconds (4), current boundary (5) and next boundary (6) into the time in one edge. The step is not added on that edge.
- R6: Add sums staged nanoseconds with the time, plus the step if enabled. Crossing the span carries into seconds as in R3.
- R7: Subtract takes staged nanoseconds from the time. Below zero, the second length is added back, seconds decrement, next takes current, and current drops by the second length.
- R8: Codes other than 0, 1, 3 and 4 change no time state and still clear after one edge.
- R9: Reset clears time, step, staging, enable, code and current boundary. The second-length register (address 7) and next boundary reset to 1,000,000,000.
- R10: Reads are combinational. Address 1 is the step, 8 is {seconds[31:0], nanoseconds} from one cycle, 9 is seconds, 10 the fraction, 11 the current boundary and 12 the next boundary. Unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 64 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 64 | Register read data |
| tod_sec | output | SEC_W | Current seconds |
| tod_ns | output | 32 | Current nanoseconds within the second |
| tod_frac | output | 32 | Current fractional nanoseconds |

## Verification
A wrong accumulator or carry shows at the time outputs on the very next edge as a nanosecond or fraction value off by a step. Any rollover or borrow bug appears as a seconds value one off at that edge. Boundary bookkeeping errors stay hidden until the following rollover, unless the boundary registers are read back, so the bench sweeps the read address through them every cycle. A stuck operation code shows at the control readback one edge after its use, and as a repeated correction in the time.

// File: rtl/tod_pkg.sv
package tod_pkg;
   localparam logic [2:0] OP_NONE = 3'd0;
   localparam logic [2:0] OP_LOAD = 3'd1;
   localparam logic [2:0] OP_ADD  = 3'd3;
   localparam logic [2:0] OP_SUB  = 3'd4;
   localparam int         OP_LSB  = 26;

   localparam logic [3:0] A_CTRL     = 4'd0;
   localparam logic [3:0] A_STEP     = 4'd1;
   localparam logic [3:0] A_STG_NS   = 4'd2;
   localparam logic [3:0] A_STG_FRAC = 4'd3;
   localparam logic [3:0] A_STG_SEC  = 4'd4;
   localparam logic [3:0] A_STG_CUR  = 4'd5;
   localparam logic [3:0] A_STG_NXT  = 4'd6;
   localparam logic [3:0] A_SEC_LEN  = 4'd7;
   localparam logic [3:0] A_NOW      = 4'd8;
   localparam logic [3:0] A_SEC      = 4'd9;
   localparam logic [3:0] A_FRAC     = 4'd10;
   localparam logic [3:0] A_CUR      = 4'd11;
   localparam logic [3:0] A_NXT      = 4'd12;

   localparam logic [63:0] NS_PER_SEC = 64'd1_000_000_000;
endpackage

// File: rtl/tod_regs.sv
module tod_regs
   import tod_pkg::*;
#(
   parameter int          SEC_W   = 48,
   parameter logic [63:0] LEN_RST = NS_PER_SEC,
   parameter bit          RD_REG  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [3:0]       wr_addr,
   input  logic [63:0]      wr_data,
   input  logic [3:0]       rd_addr,
   input  logic [SEC_W-1:0] t_sec,
   input  logic [31:0]      t_ns,
   input  logic [31:0]      t_frac,
   input  logic [63:0]      t_cur,
   input  logic [63:0]      t_nxt,
   output logic             en,
   output logic [2:0]       op,
   output logic [63:0]      step,
   output logic [31:0]      stg_ns,
   output logic [31:0]      stg_frac,
   output logic [SEC_W-1:0] stg_sec,
   output logic [63:0]      stg_cur,
   output logic [63:0]      stg_nxt,
   output logic [63:0]      sec_len,
   output logic [63:0]      rd_data
);
   logic [63:0] rd_mux;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en       <= 1'b0;
         op       <= OP_NONE;
         step     <= '0;
         stg_ns   <= '0;
         stg_frac <= '0;
         stg_sec  <= '0;
         stg_cur  <= '0;
         stg_nxt  <= '0;
         sec_len  <= LEN_RST;
      end else begin
         if (op != OP_NONE) op <= OP_NONE;
         if (wr_en) begin
            case (wr_addr)
               A_CTRL: begin
                  en <= wr_data[0];
                  op <= wr_data[OP_LSB +: 3];
               end
               A_STEP:     step     <= wr_data;
               A_STG_NS:   stg_ns   <= wr_data[31:0];
               A_STG_FRAC: stg_frac <= wr_data[31:0];
               A_STG_SEC:  stg_sec  <= wr_data[SEC_W-1:0];
               A_STG_CUR:  stg_cur  <= wr_data;
               A_STG_NXT:  stg_nxt  <= wr_data;
               A_SEC_LEN:  sec_len  <= wr_data;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (rd_addr)
         A_CTRL:     rd_mux = 64'(en) | (64'(op) << OP_LSB);
         A_STEP:     rd_mux = step;
         A_STG_NS:   rd_mux = 64'(stg_ns);
         A_STG_FRAC: rd_mux = 64'(stg_frac);
         A_STG_SEC:  rd_mux = 64'(stg_sec);
         A_STG_CUR:  rd_mux = stg_cur;
         A_STG_NXT:  rd_mux = stg_nxt;
         A_SEC_LEN:  rd_mux = sec_len;
         A_NOW:      rd_mux = {t_sec[31:0], t_ns};
         A_SEC:      rd_mux = 64'(t_sec);
         A_FRAC:     rd_mux = 64'(t_frac);
         A_CUR:      rd_mux = t_cur;
         A_NXT:      rd_mux = t_nxt;
         default:    rd_mux = '0;
      endcase
   end

   generate
      if (RD_REG) begin : g_rd_flop
         logic [63:0] rd_q;
         always_ff @(posedge clk) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_mux;
         end
         assign rd_data = rd_q;
      end else begin : g_rd_comb
         assign rd_data = rd_mux;
      end
   endgenerate

   // R4: a pending code is consumed after one edge unless rewritten
   p_op_selfclear_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (op != OP_NONE && !(wr_en && wr_addr == A_CTRL)) |=> (op == OP_NONE));
endmodule

// File: rtl/tod_step.sv
module tod_step
   import tod_pkg::*;
#(
   parameter int SEC_W = 48
) (
   input  logic             en,
   input  logic [2:0]       op,
   input  logic [63:0]      step,
   input  logic [31:0]      stg_ns,
   input  logic [63:0]      sec_len,
   input  logic [SEC_W-1:0] t_sec,
   input  logic [31:0]      t_ns,
   input  logic [31:0]      t_frac,
   input  logic [63:0]      t_cur,
   input  logic [63:0]      t_nxt,
   output logic [SEC_W-1:0] n_sec,
   output logic [31:0]      n_ns,
   output logic [31:0]      n_frac,
   output logic [63:0]      n_cur,
   output logic [63:0]      n_nxt,
   output logic             carry,
   output logic             borrow
);
   localparam int SW = 64 + 3;

   logic [31:0]          span;
   logic signed [SW-1:0] sum, span_fx, len_fx, adj_fx, res;

   always_comb begin
      span    = t_nxt[31:0] - t_cur[31:0];
      span_fx = $signed({3'b000, span, 32'd0});
      len_fx  = $signed({3'b000, sec_len[31:0], 32'd0});
      adj_fx  = $signed({3'b000, stg_ns, 32'd0});
      sum     = $signed({3'b000, t_ns, t_frac});
      if (en) sum = sum + $signed({3'b000, step});
      if (op == OP_ADD)      sum = sum + adj_fx;
      else if (op == OP_SUB) sum = sum - adj_fx;

      borrow = sum[SW-1];
      carry  = !sum[SW-1] && (sum >= span_fx);

      n_sec = t_sec;
      n_cur = t_cur;
      n_nxt = t_nxt;
      res   = sum;
      if (carry) begin
         res   = sum - span_fx;
         n_sec = t_sec + 1'b1;
         n_cur = t_nxt;
         n_nxt = t_nxt + sec_len;
      end else if (borrow) begin
         res   = sum + len_fx;
         n_sec = t_sec - 1'b1;
         n_cur = t_cur - sec_len;
         n_nxt = t_cur;
      end
      n_ns   = res[63:32];
      n_frac = res[31:0];
   end
endmodule

// File: rtl/tod_state.sv
module tod_state
   import tod_pkg::*;
#(
   parameter int          SEC_W   = 48,
   parameter logic [63:0] LEN_RST = NS_PER_SEC
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [2:0]       op,
   input  logic [31:0]      stg_ns,
   input  logic [31:0]      stg_frac,
   input  logic [SEC_W-1:0] stg_sec,
   input  logic [63:0]      stg_cur,
   input  logic [63:0]      stg_nxt,
   input  logic [SEC_W-1:0] n_sec,
   input  logic [31:0]      n_ns,
   input  logic [31:0]      n_frac,
   input  logic [63:0]      n_cur,
   input  logic [63:0]      n_nxt,
   input  logic             carry,
   input  logic             borrow,
   output logic [SEC_W-1:0] t_sec,
   output logic [31:0]      t_ns,
   output logic [31:0]      t_frac,
   output logic [63:0]      t_cur,
   output logic [63:0]      t_nxt
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         t_sec  <= '0;
         t_ns   <= '0;
         t_frac <= '0;
         t_cur  <= '0;
         t_nxt  <= LEN_RST;
      end else if (op == OP_LOAD) begin
         t_sec  <= stg_sec;
         t_ns   <= stg_ns;
         t_frac <= stg_frac;
         t_cur  <= stg_cur;
         t_nxt  <= stg_nxt;
      end else begin
         t_sec  <= n_sec;
         t_ns   <= n_ns;
         t_frac <= n_frac;
         t_cur  <= n_cur;
         t_nxt  <= n_nxt;
      end
   end

   // R3: nanoseconds stay inside the running second
   p_ns_below_span_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (64'(t_ns) < (t_nxt - t_cur)));

   // R3: a rollover hands the next boundary to the current one
   p_roll_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (carry && op != OP_LOAD) |=> (t_cur == $past(t_nxt)));

   // R7: a borrow moves the next boundary back to the old current one
   p_borrow_back_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (borrow && op != OP_LOAD) |=> (t_nxt == $past(t_cur)));

   // R2: disabled and idle means frozen time
   p_hold_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && op == OP_NONE) |=> ($stable(t_ns) && $stable(t_frac) && $stable(t_sec)));

   // R6: outside a load the seconds move by at most one per edge
   p_sec_single_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (op != OP_LOAD) |=> (t_sec == $past(t_sec) || t_sec == $past(t_sec) + 1'b1
                           || t_sec == $past(t_sec) - 1'b1));
endmodule

// File: rtl/tod_counter.sv
module tod_counter
   import tod_pkg::*;
#(
   parameter int          SEC_W   = 48,
   parameter logic [63:0] LEN_RST = NS_PER_SEC,
   parameter bit          RD_REG  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [3:0]       wr_addr,
   input  logic [63:0]      wr_data,
   input  logic [3:0]       rd_addr,
   output logic [63:0]      rd_data,
   output logic [SEC_W-1:0] tod_sec,
   output logic [31:0]      tod_ns,
   output logic [31:0]      tod_frac
);
   generate
      if (SEC_W < 32 || SEC_W > 64) begin : g_bad_sec_w
         $error("tod_counter: SEC_W must lie in 32..64");
      end
      if (LEN_RST == 64'd0 || LEN_RST > 64'hFFFF_FFFF) begin : g_bad_len
         $error("tod_counter: LEN_RST must be nonzero and fit 32 bits");
      end
   endgenerate

   logic             en;
   logic [2:0]       op;
   logic [63:0]      step, stg_cur, stg_nxt, sec_len;
   logic [31:0]      stg_ns, stg_frac;
   logic [SEC_W-1:0] stg_sec;
   logic [SEC_W-1:0] t_sec, n_sec;
   logic [31:0]      t_ns, t_frac, n_ns, n_frac;
   logic [63:0]      t_cur, t_nxt, n_cur, n_nxt;
   logic             carry, borrow;

   tod_regs #(.SEC_W(SEC_W), .LEN_RST(LEN_RST), .RD_REG(RD_REG)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .t_sec(t_sec), .t_ns(t_ns), .t_frac(t_frac),
      .t_cur(t_cur), .t_nxt(t_nxt), .en(en), .op(op), .step(step),
      .stg_ns(stg_ns), .stg_frac(stg_frac), .stg_sec(stg_sec),
      .stg_cur(stg_cur), .stg_nxt(stg_nxt), .sec_len(sec_len), .rd_data(rd_data)
   );

   tod_step #(.SEC_W(SEC_W)) u_step (
      .en(en), .op(op), .step(step), .stg_ns(stg_ns), .sec_len(sec_len),
      .t_sec(t_sec), .t_ns(t_ns), .t_frac(t_frac), .t_cur(t_cur), .t_nxt(t_nxt),
      .n_sec(n_sec), .n_ns(n_ns), .n_frac(n_frac), .n_cur(n_cur), .n_nxt(n_nxt),
      .carry(carry), .borrow(borrow)
   );

   tod_state #(.SEC_W(SEC_W), .LEN_RST(LEN_RST)) u_state (
      .clk(clk), .rst_n(rst_n), .en(en), .op(op),
      .stg_ns(stg_ns), .stg_frac(stg_frac), .stg_sec(stg_sec),
      .stg_cur(stg_cur), .stg_nxt(stg_nxt),
      .n_sec(n_sec), .n_ns(n_ns), .n_frac(n_frac), .n_cur(n_cur), .n_nxt(n_nxt),
      .carry(carry), .borrow(borrow),
      .t_sec(t_sec), .t_ns(t_ns), .t_frac(t_frac), .t_cur(t_cur), .t_nxt(t_nxt)
   );

   assign tod_sec  = t_sec;
   assign tod_ns   = t_ns;
   assign tod_frac = t_frac;
endmodule

// File: tb/tod_counter_tb.sv
module tod_counter_tb;
   localparam int SW = 48;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          wr_en;
   logic [3:0]    wr_addr;
   logic [63:0]   wr_data;
   logic [3:0]    rd_addr;
   logic [63:0]   rd_data;
   logic [SW-1:0] tod_sec;
   logic [31:0]   tod_ns, tod_frac;

   always #10 clk = ~clk;

   tod_counter u_dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .tod_sec(tod_sec), .tod_ns(tod_ns),
      .tod_frac(tod_frac)
   );

   int    n_vec = 0;
   int    n_bad = 0;
   bit    done = 0;
   string phase = "R9";

   // behavioural model
   bit                 m_en;
   int                 m_op;
   logic [63:0]        m_step, m_scur, m_snxt, m_len;
   logic [31:0]        m_sns, m_sfrac;
   logic [SW-1:0]      m_ssec, m_sec;
   logic signed [63:0] m_acc;
   logic [63:0]        m_cur, m_nxt;

   task automatic model_reset();
      m_en = 0; m_op = 0; m_step = 0; m_scur = 0; m_snxt = 0;
      m_len = 64'd1_000_000_000; m_sns = 0; m_sfrac = 0; m_ssec = 0;
      m_sec = 0; m_acc = 0; m_cur = 0; m_nxt = 64'd1_000_000_000;
   endtask

   task automatic model_step(input logic we, input logic [3:0] a, input logic [63:0] d);
      logic signed [63:0] sum, span;
      logic [63:0] oc;
      if (m_op == 1) begin
         m_acc = $signed({m_sns, m_sfrac});
         m_sec = m_ssec; m_cur = m_scur; m_nxt = m_snxt;
      end else begin
         sum = m_acc;
         if (m_en) sum = sum + $signed(m_step);
         if (m_op == 3) sum = sum + $signed({m_sns, 32'd0});
         if (m_op == 4) sum = sum - $signed({m_sns, 32'd0});
         span = $signed({32'd0, 32'(m_nxt - m_cur)}) <<< 32;
         if (sum >= span) begin
            sum = sum - span; m_sec = m_sec + 1'b1;
            m_cur = m_nxt; m_nxt = m_nxt + m_len;
         end else if (sum < 0) begin
            sum = sum + ($signed({32'd0, m_len[31:0]}) <<< 32);
            m_sec = m_sec - 1'b1;
            oc = m_cur; m_cur = m_cur - m_len; m_nxt = oc;
         end
         m_acc = sum;
      end
      m_op = 0;
      if (we) begin
         case (a)
            4'd0: begin m_en = d[0]; m_op = int'(d[28:26]); end
            4'd1: m_step = d;
            4'd2: m_sns = d[31:0];
            4'd3: m_sfrac = d[31:0];
            4'd4: m_ssec = d[SW-1:0];
            4'd5: m_scur = d;
            4'd6: m_snxt = d;
            4'd7: m_len = d;
            default: ;
         endcase
      end
   endtask

   function automatic logic [63:0] model_read(input logic [3:0] a);
      case (a)
         4'd0:  return 64'(m_en) | (64'(m_op) << 26);
         4'd1:  return m_step;
         4'd2:  return 64'(m_sns);
         4'd3:  return 64'(m_sfrac);
         4'd4:  return 64'(m_ssec);
         4'd5:  return m_scur;
         4'd6:  return m_snxt;
         4'd7:  return m_len;
         4'd8:  return {m_sec[31:0], m_acc[63:32]};
         4'd9:  return 64'(m_sec);
         4'd10: return 64'(m_acc[31:0]);
         4'd11: return m_cur;
         4'd12: return m_nxt;
         default: return 64'd0;
      endcase
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic compare_all();
      chk({phase, " ns"},   64'(tod_ns),   64'(m_acc[63:32]));
      chk({phase, " frac"}, 64'(tod_frac), 64'(m_acc[31:0]));
      chk({phase, " sec"},  64'(tod_sec),  64'(m_sec));
      chk({phase, " rd R10"}, rd_data, model_read(rd_addr));
   endtask

   task automatic cyc(input logic we, input logic [3:0] a, input logic [63:0] d);
      wr_en = we; wr_addr = a; wr_data = d;
      model_step(we, a, d);
      @(negedge clk);
      wr_en = 1'b0;
      compare_all();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) cyc(1'b0, 4'd0, 64'd0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   initial begin
      int cnt;
      cnt = 0;
      forever begin
         @(posedge clk);
         cnt++;
         if (cnt > 100000) begin
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cnt);
            finish_run();
         end
      end
   end

   initial begin
      rst_n = 1'b0; wr_en = 1'b0; wr_addr = 0; wr_data = 0; rd_addr = 0;
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R9: reset values
      phase = "R9";
      rd_addr = 4'd1;  cyc(1'b0, 0, 0); chk("R9 step", rd_data, 64'd0);
      rd_addr = 4'd7;  cyc(1'b0, 0, 0); chk("R9 sec len", rd_data, 64'd1_000_000_000);
      rd_addr = 4'd12; cyc(1'b0, 0, 0); chk("R9 next", rd_data, 64'd1_000_000_000);
      chk("R9 ns", 64'(tod_ns), 64'd0);

      // R2: step programmed but not enabled
      phase = "R2";
      cyc(1'b1, 4'd1, 64'h8_0000_0000);
      idle(3);
      chk("R2 frozen ns", 64'(tod_ns), 64'd0);

      // R1: enable, 8 ns per cycle
      phase = "R1";
      cyc(1'b1, 4'd0, 64'd1);
      idle(4);
      chk("R1 ns after 4", 64'(tod_ns), 64'd32);

      // R5 load then R3 rollover with excess
      phase = "R5";
      cyc(1'b1, 4'd2, 64'd999_999_980);
      cyc(1'b1, 4'd3, 64'd0);
      cyc(1'b1, 4'd4, 64'd5);
      cyc(1'b1, 4'd5, 64'd0);
      cyc(1'b1, 4'd6, 64'd1_000_000_000);
      rd_addr = 4'd0;
      cyc(1'b1, 4'd0, (64'd1 << 26) | 64'd1);
      chk("R4 pending code", rd_data, (64'd1 << 26) | 64'd1);
      idle(1);
      chk("R5 ns", 64'(tod_ns), 64'd999_999_980);
      chk("R5 sec", 64'(tod_sec), 64'd5);
      chk("R4 code cleared", rd_data, 64'd1);
      phase = "R3";
      idle(3);
      chk("R3 excess ns", 64'(tod_ns), 64'd4);
      chk("R3 sec", 64'(tod_sec), 64'd6);
      rd_addr = 4'd11; idle(1); chk("R3 cur", rd_data, 64'd1_000_000_000);
      rd_addr = 4'd12; idle(1); chk("R3 nxt", rd_data, 64'd2_000_000_000);

      // R1 fractional step 2.5 ns
      phase = "R1";
      cyc(1'b1, 4'd1, 64'h2_8000_0000);
      idle(5);

      // frozen-time corrections
      phase = "R5";
      cyc(1'b1, 4'd2, 64'd500_000_000);
      cyc(1'b1, 4'd4, 64'd10);
      cyc(1'b1, 4'd6, 64'd1_000_000_000);
      cyc(1'b1, 4'd0, 64'd1 << 26);
      idle(1);
      chk("R5 frozen load ns", 64'(tod_ns), 64'd500_000_000);
      phase = "R6";
      cyc(1'b1, 4'd2, 64'd600_000_000);
      cyc(1'b1, 4'd0, 64'd3 << 26);
      idle(1);
      chk("R6 carry ns", 64'(tod_ns), 64'd100_000_000);
      chk("R6 carry sec", 64'(tod_sec), 64'd11);
      phase = "R7";
      cyc(1'b1, 4'd2, 64'd300_000_000);
      cyc(1'b1, 4'd0, 64'd4 << 26);
      rd_addr = 4'd11;
      idle(1);
      chk("R7 borrow ns", 64'(tod_ns), 64'd800_000_000);
      chk("R7 borrow sec", 64'(tod_sec), 64'd10);
      chk("R7 cur", rd_data, 64'd0);
      phase = "R8";
      rd_addr = 4'd0;
      cyc(1'b1, 4'd0, 64'd2 << 26);
      idle(1);
      chk("R8 code cleared", rd_data, 64'd0);
      chk("R8 ns held", 64'(tod_ns), 64'd800_000_000);
      phase = "R10";
      rd_addr = 4'd8;
      idle(1);
      chk("R10 pair", rd_data, {32'd10, 32'd800_000_000});

      // running with fractional step across a rollover, then corrections
      phase = "R3";
      cyc(1'b1, 4'd1, 64'h3_5555_5555);
      cyc(1'b1, 4'd2, 64'd999_999_000);
      cyc(1'b1, 4'd4, 64'd20);
      cyc(1'b1, 4'd0, (64'd1 << 26) | 64'd1);
      for (int i = 0; i < 400; i++) begin
         rd_addr = 4'(i % 14);
         cyc(1'b0, 0, 0);
      end
      phase = "R7";
      cyc(1'b1, 4'd2, 64'd999_999_500);
      cyc(1'b1, 4'd0, (64'd4 << 26) | 64'd1);
      idle(3);
      phase = "R6";
      cyc(1'b1, 4'd7, 64'd1_000_000_000);
      cyc(1'b1, 4'd2, 64'd999_999_990);
      cyc(1'b1, 4'd0, (64'd3 << 26) | 64'd1);
      for (int i = 0; i < 40; i++) begin
         rd_addr = 4'(i % 14);
         cyc(1'b0, 0, 0);
      end
      finish_run();
   end
endmodule